// File: doc/BRIEF.md
# Byte-Masked Configuration Register Space

This block holds the 256-byte configuration space of one peripheral function with a Type 0 header. A host reaches it through a 32-bit configuration address, an access size and a data word. The address carries a bus number, a combined device/function number and a byte offset. The block answers only when the bus and device/function fields match the numbers presented on its own strap inputs. Reads and writes of one, two or four bytes are taken in little-endian order at any byte offset, with no alignment required.

Each byte has its own write mask. A write merges the incoming byte into the stored byte under that mask. Identity fields, header type and every other fixed header byte therefore keep their values. The command decode bits, cache line size, interrupt line, the address bits of each base address register (set per register by a parameter) and the whole device-specific region from offset 0x40 upward can be changed.

A single-cycle remap request tells the surrounding address decoder that a window may have moved. It is raised when a write changes any byte of the base address register window, or when it flips the I/O or memory decode enable. The 64 header bytes are held in flip-flops with per-byte reset values. The 192 device-specific bytes sit in four byte-wide memories that can be inferred as block RAM.

Top module: `cfg_space_ctl`

## Requirements
- R1: The configuration address is split into bus number bits 23:16, device/function bits 15:8 (device 15:11, function 10:8) and byte offset bits 7:0. An access is taken only when the bus field equals `my_bus` and the device/function field equals `my_devfn`.
- R2: `acc_size` codes are 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 = 4 bytes. Code 2'b11 is reserved: a write with it changes nothing, and a read with it returns 32'hFFFF_FFFF.
- R3: A write stores its bytes at offset, offset+1 and so on, starting with `wr_data[7:0]`. A byte whose offset would pass 255 is dropped and never wraps to offset 0.
- R4: Each written byte becomes (old AND NOT mask) OR (data AND mask), using the write mask of its own offset.
- R5: The write masks are: 0x07 at offset 0x04 (I/O enable bit 0, memory enable bit 1, bus master bit 2); 0xFF at 0x0C (cache line size) and at 0x3C (interrupt line); the `BAR_WMASK` bytes over the base address window 0x10 to 0x27 (default 0xFFFF_F000 for the first register, 0xFFFF_FFFC for the second, zero for the rest); 0xFF from 0x40 to 0xFF. Every other header byte has mask 0x00.
- R6: On synchronous reset the header is loaded as follows: vendor ID at 0x00, device ID at 0x02, revision at 0x08, class code at 0x09 to 0x0B, subsystem vendor ID at 0x2C, subsystem ID at 0x2E (all little-endian, from the identity inputs). The base address window takes `BAR_FLAGS` (default: second register = 0x0000_0001). All other header bytes are zero. Outputs are zero while in reset.
- R7: A read returns the addressed bytes little-endian in `rd_data`, with bytes beyond the access size zero. `rd_valid` is high for exactly one cycle, two clock edges after the edge that samples `rd_en`.
- R8: A 4-byte read at an offset above 0xFC, or a 2-byte read at an offset above 0xFE, returns 32'hFFFF_FFFF.
- R9: A read whose bus or device/function field does not match returns 32'hFFFF_FFFF. A write whose fields do not match changes nothing.
- R10: `remap_req` is high for one cycle, one edge after a write that changes a byte in 0x10 to 0x27 or changes bit 0 or bit 1 of offset 0x04. A write that leaves those bits unchanged raises no request.
- R11: When `wr_en` and `rd_en` are high in the same cycle, the write is performed and the read is dropped with no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_bus | input | 8 | Bus number this function answers on |
| my_devfn | input | 8 | Device/function number of this function |
| id_vendor | input | 16 | Vendor ID loaded at reset |
| id_device | input | 16 | Device ID loaded at reset |
| id_revision | input | 8 | Revision loaded at reset |
| id_class | input | 24 | Class code loaded at reset |
| id_subvendor | input | 16 | Subsystem vendor ID loaded at reset |
| id_subsystem | input | 16 | Subsystem ID loaded at reset |
| cfg_addr | input | 32 | Configuration address (bus, device/function, offset) |
| acc_size | input | 2 | Access size code |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_data | input | 32 | Write data, least significant byte to the lowest offset |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid pulse |
| remap_req | output | 1 | Request to recompute address windows |

## Verification
A write's effect on `remap_req` appears after the first clock edge following the cycle in which the write is presented. Read data and `rd_valid` appear after the second edge, because the lane select and the memory output each take one register stage. The bench keeps a four-slot ring of expected outputs indexed by cycle count. Each access schedules its result one or two slots ahead from a behavioural byte array, and every cycle at the falling edge both outputs are compared against the slot for that cycle. A dropped or mismatched access therefore shows as a missing or extra pulse exactly where it is due.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // fixed header layout
  localparam int OFS_VENDOR    = 8'h00;
  localparam int OFS_DEVICE    = 8'h02;
  localparam int OFS_COMMAND   = 8'h04;
  localparam int OFS_REVISION  = 8'h08;
  localparam int OFS_CLASS     = 8'h09;
  localparam int OFS_CACHELINE = 8'h0C;
  localparam int OFS_BAR_BASE  = 8'h10;
  localparam int OFS_SUBVENDOR = 8'h2C;
  localparam int OFS_SUBSYSTEM = 8'h2E;
  localparam int OFS_IRQ_LINE  = 8'h3C;

  localparam logic [7:0] CMD_WMASK   = 8'h07;
  localparam logic [7:0] CMD_DECODE  = 8'h03;

  function automatic int size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/cfg_space_decode.sv
module cfg_space_decode
  import cfg_space_pkg::*;
#(
  parameter int SPACE_BYTES = 256,
  parameter int OFF_W       = $clog2(SPACE_BYTES)
) (
  input  logic [23:0]                  addr_lo,
  input  logic [1:0]                   acc_size,
  input  logic [7:0]                   my_bus,
  input  logic [7:0]                   my_devfn,
  output logic                         acc_ok,
  output logic                         rd_fault,
  output logic [LANES-1:0]             lane_on,
  output logic [LANES-1:0][OFF_W-1:0]  lane_addr
);

  logic             hit;
  logic [OFF_W-1:0] base;
  logic [OFF_W:0]   sum;
  int               nbytes;

  always_comb begin
    nbytes   = size_bytes(acc_size_e'(acc_size));
    hit      = (addr_lo[23:16] == my_bus) && (addr_lo[15:8] == my_devfn);
    base     = addr_lo[OFF_W-1:0];
    acc_ok   = hit && (nbytes != 0);
    rd_fault = !acc_ok ||
               (({1'b0, base} + (OFF_W+1)'(nbytes)) > (OFF_W+1)'(SPACE_BYTES));
    sum      = '0;
    for (int i = 0; i < LANES; i++) begin
      sum          = {1'b0, base} + (OFF_W+1)'(i);
      lane_addr[i] = sum[OFF_W-1:0];
      lane_on[i]   = (i < nbytes) && !sum[OFF_W];
    end
  end

endmodule

// File: rtl/cfg_space_hdr.sv
module cfg_space_hdr
  import cfg_space_pkg::*;
#(
  parameter int HDR_BYTES = 64,
  parameter int OFF_W     = 8,
  parameter int BAR_COUNT = 6,
  parameter logic [BAR_COUNT*32-1:0] BAR_WMASK = '0,
  parameter logic [BAR_COUNT*32-1:0] BAR_FLAGS = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [HDR_BYTES*8-1:0]       init_flat,
  input  logic                         wr_go,
  input  logic [LANES-1:0]             lane_on,
  input  logic [LANES-1:0][OFF_W-1:0]  lane_addr,
  input  logic [31:0]                  wr_data,
  output logic [LANES-1:0][7:0]        rd_byte,
  output logic                         remap_req
);

  localparam int HDR_W  = $clog2(HDR_BYTES);
  localparam int BAR_LO = OFS_BAR_BASE;
  localparam int BAR_HI = OFS_BAR_BASE + 4*BAR_COUNT;

  function automatic logic [7:0] byte_wmask(int j);
    if (j == OFS_COMMAND) return CMD_WMASK;
    if (j == OFS_CACHELINE || j == OFS_IRQ_LINE) return 8'hFF;
    if (j >= BAR_LO && j < BAR_HI) return BAR_WMASK[8*(j-BAR_LO) +: 8];
    return 8'h00;
  endfunction

  function automatic logic [7:0] byte_remap(int j);
    if (j == OFS_COMMAND) return CMD_DECODE;
    if (j >= BAR_LO && j < BAR_HI) return 8'hFF;
    return 8'h00;
  endfunction

  logic [HDR_BYTES*8-1:0] hdr_flat;
  logic [HDR_BYTES-1:0]   remap_hit;

  for (genvar j = 0; j < HDR_BYTES; j++) begin : g_byte
    localparam logic [7:0] WM = byte_wmask(j);
    localparam logic [7:0] RM = byte_remap(j);
    logic [7:0] q, din, nxt;
    logic       sel;

    always_comb begin
      sel = 1'b0;
      din = 8'h00;
      for (int i = 0; i < LANES; i++) begin
        if (wr_go && lane_on[i] && lane_addr[i] == OFF_W'(j)) begin
          sel = 1'b1;
          din = wr_data[8*i +: 8];
        end
      end
      nxt = (q & ~WM) | (din & WM);
    end

    assign remap_hit[j]       = sel && (((nxt ^ q) & RM) != 8'h00);
    assign hdr_flat[8*j +: 8] = q;

    always_ff @(posedge clk) begin
      if (rst)      q <= init_flat[8*j +: 8];
      else if (sel) q <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) remap_req <= 1'b0;
    else     remap_req <= |remap_hit;
    for (int i = 0; i < LANES; i++)
      rd_byte[i] <= hdr_flat[8*lane_addr[i][HDR_W-1:0] +: 8];
  end

endmodule

// File: rtl/cfg_space_bank.sv
module cfg_space_bank #(
  parameter int DEPTH = 48,
  parameter int ROW_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wbyte;
    rbyte <= mem[row];
  end

endmodule

// File: rtl/cfg_space_ctl.sv
module cfg_space_ctl
  import cfg_space_pkg::*;
#(
  parameter int SPACE_BYTES = 256,
  parameter int HDR_BYTES   = 64,
  parameter int BAR_COUNT   = 6,
  parameter logic [BAR_COUNT*32-1:0] BAR_WMASK =
    {32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFC, 32'hFFFF_F000},
  parameter logic [BAR_COUNT*32-1:0] BAR_FLAGS =
    {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 32'h0}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  my_bus,
  input  logic [7:0]  my_devfn,
  input  logic [15:0] id_vendor,
  input  logic [15:0] id_device,
  input  logic [7:0]  id_revision,
  input  logic [23:0] id_class,
  input  logic [15:0] id_subvendor,
  input  logic [15:0] id_subsystem,
  input  logic [31:0] cfg_addr,
  input  logic [1:0]  acc_size,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        remap_req
);

  localparam int OFF_W = $clog2(SPACE_BYTES);
  localparam int LSB_W = $clog2(LANES);
  localparam int ROWS  = (SPACE_BYTES - HDR_BYTES) / LANES;
  localparam int ROW_W = $clog2(ROWS);
  localparam int HDR_ROWS = HDR_BYTES / LANES;

  logic                        acc_ok, rd_fault, wr_go, rd_go;
  logic [LANES-1:0]            lane_on;
  logic [LANES-1:0][OFF_W-1:0] lane_addr;
  logic [LSB_W-1:0]            off_lo;

  cfg_space_decode #(.SPACE_BYTES(SPACE_BYTES), .OFF_W(OFF_W)) u_dec (
    .addr_lo   (cfg_addr[23:0]),
    .acc_size  (acc_size),
    .my_bus    (my_bus),
    .my_devfn  (my_devfn),
    .acc_ok    (acc_ok),
    .rd_fault  (rd_fault),
    .lane_on   (lane_on),
    .lane_addr (lane_addr)
  );

  assign wr_go  = wr_en && acc_ok;
  assign rd_go  = rd_en && !wr_en;
  assign off_lo = cfg_addr[LSB_W-1:0];

  // reset image of the header
  logic [HDR_BYTES*8-1:0] init_flat;
  always_comb begin
    init_flat = '0;
    init_flat[8*OFS_BAR_BASE  +: 32*BAR_COUNT] = BAR_FLAGS;
    init_flat[8*OFS_VENDOR    +: 16] = id_vendor;
    init_flat[8*OFS_DEVICE    +: 16] = id_device;
    init_flat[8*OFS_REVISION  +: 8]  = id_revision;
    init_flat[8*OFS_CLASS     +: 24] = id_class;
    init_flat[8*OFS_SUBVENDOR +: 16] = id_subvendor;
    init_flat[8*OFS_SUBSYSTEM +: 16] = id_subsystem;
  end

  logic [LANES-1:0][7:0] hdr_rd;

  cfg_space_hdr #(
    .HDR_BYTES (HDR_BYTES),
    .OFF_W     (OFF_W),
    .BAR_COUNT (BAR_COUNT),
    .BAR_WMASK (BAR_WMASK),
    .BAR_FLAGS (BAR_FLAGS)
  ) u_hdr (
    .clk       (clk),
    .rst       (rst),
    .init_flat (init_flat),
    .wr_go     (wr_go),
    .lane_on   (lane_on),
    .lane_addr (lane_addr),
    .wr_data   (wr_data),
    .rd_byte   (hdr_rd),
    .remap_req (remap_req)
  );

  // device-specific region: one byte-wide memory per byte lane of a row
  logic [LANES-1:0][7:0] bank_rd;

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [LSB_W-1:0] li;
    logic [OFF_W-1:0] baddr;
    logic [ROW_W-1:0] brow;
    logic             bwe;
    logic [7:0]       bdin;

    always_comb begin
      li    = LSB_W'(b) - off_lo;
      baddr = lane_addr[li];
      bwe   = wr_go && lane_on[li] && (int'(baddr) >= HDR_BYTES);
      brow  = ROW_W'(int'(baddr[OFF_W-1:LSB_W]) - HDR_ROWS);
      bdin  = wr_data[8*li +: 8];
    end

    cfg_space_bank #(.DEPTH(ROWS), .ROW_W(ROW_W)) u_bank (
      .clk   (clk),
      .we    (bwe),
      .row   (brow),
      .wbyte (bdin),
      .rbyte (bank_rd[b])
    );
  end

  // read stage 1: remember lane routing while memories respond
  logic             rd_s1, fault_s1;
  logic [LSB_W-1:0] off_s1;
  logic [LANES-1:0] on_s1, hdr_s1;

  always_ff @(posedge clk) begin
    if (rst) rd_s1 <= 1'b0;
    else     rd_s1 <= rd_go;
    fault_s1 <= rd_fault;
    off_s1   <= off_lo;
    for (int i = 0; i < LANES; i++) begin
      on_s1[i]  <= lane_on[i];
      hdr_s1[i] <= int'(lane_addr[i]) < HDR_BYTES;
    end
  end

  // read stage 2: assemble little-endian word
  logic [31:0] rd_asm;
  always_comb begin
    rd_asm = '0;
    for (int i = 0; i < LANES; i++) begin
      if (on_s1[i])
        rd_asm[8*i +: 8] = hdr_s1[i] ? hdr_rd[i]
                                     : bank_rd[LSB_W'(off_s1 + LSB_W'(i))];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_s1;
      if (rd_s1) rd_data <= fault_s1 ? 32'hFFFF_FFFF : rd_asm;
    end
  end

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  my_bus,
  input logic [7:0]  my_devfn,
  input logic [31:0] cfg_addr,
  input logic [1:0]  acc_size,
  input logic        wr_en,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        remap_req
);

  logic       hit;
  logic [1:0] rd_sr, miss_sr, one_sr;

  assign hit = (cfg_addr[23:16] == my_bus) && (cfg_addr[15:8] == my_devfn);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sr   <= '0;
      miss_sr <= '0;
      one_sr  <= '0;
    end else begin
      rd_sr   <= {rd_sr[0],   rd_en && !wr_en};
      miss_sr <= {miss_sr[0], !hit};
      one_sr  <= {one_sr[0],  acc_size == 2'b00};
    end
  end

  // R7 R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid == rd_sr[1]);

  // R9
  miss_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && miss_sr[1]) |-> rd_data == 32'hFFFF_FFFF);

  // R7
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && one_sr[1] && !miss_sr[1]) |-> rd_data[31:8] == 24'h0);

  // R10
  remap_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    remap_req |-> $past(wr_en && hit && acc_size != 2'b11));

  // R10
  remap_single_chk: assert property (@(posedge clk) disable iff (rst)
    (remap_req && !$past(wr_en)) |=> !remap_req);

endmodule

bind cfg_space_ctl cfg_space_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .my_bus    (my_bus),
  .my_devfn  (my_devfn),
  .cfg_addr  (cfg_addr),
  .acc_size  (acc_size),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .remap_req (remap_req)
);

// File: tb/cfg_space_ctl_test.sv
module cfg_space_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MY_BUS   = 8'h03;
  localparam logic [7:0] MY_DEVFN = 8'h28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid, remap_req;

  localparam logic [15:0] VEN = 16'hC0DE, DEV = 16'h7A31;
  localparam logic [7:0]  REV = 8'h05;
  localparam logic [23:0] CLS = 24'h020000;
  localparam logic [15:0] SVEN = 16'h5EED, SSYS = 16'h0042;

  cfg_space_ctl uut (
    .clk(clk), .rst(rst), .my_bus(MY_BUS), .my_devfn(MY_DEVFN),
    .id_vendor(VEN), .id_device(DEV), .id_revision(REV), .id_class(CLS),
    .id_subvendor(SVEN), .id_subsystem(SSYS),
    .cfg_addr(cfg_addr), .acc_size(acc_size), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .remap_req(remap_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  logic [7:0]  mem [256];
  logic        exp_v [4];
  logic [31:0] exp_d [4];
  string       exp_t [4];
  logic        exp_r [4];

  function automatic logic [31:0] mk(input logic [7:0] bus, input logic [7:0] devfn,
                                     input logic [7:0] off);
    return {8'h00, bus, devfn, off};
  endfunction
  function automatic logic [31:0] A(input logic [7:0] off);
    return mk(MY_BUS, MY_DEVFN, off);
  endfunction

  function automatic logic [7:0] spec_mask(input int a);
    if (a == 4) return 8'h07;
    if (a == 8'h0C || a == 8'h3C) return 8'hFF;
    if (a >= 8'h10 && a <= 8'h13) return (32'hFFFF_F000 >> (8*(a-8'h10))) & 8'hFF;
    if (a >= 8'h14 && a <= 8'h17) return (32'hFFFF_FFFC >> (8*(a-8'h14))) & 8'hFF;
    if (a >= 8'h40) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
  endfunction

  function automatic bit is_hit(input logic [31:0] a);
    return a[23:16] == MY_BUS && a[15:8] == MY_DEVFN;
  endfunction

  function automatic logic [31:0] model_read(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v;
    int n, off;
    n = nb(sz);
    off = int'(a[7:0]);
    if (!is_hit(a) || n == 0 || off + n > 256) return 32'hFFFF_FFFF;
    v = '0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = mem[off+i];
    return v;
  endfunction

  function automatic bit model_write(input logic [31:0] a, input logic [1:0] sz,
                                     input logic [31:0] d);
    bit flag;
    int n, off;
    logic [7:0] m, nv;
    flag = 1'b0;
    n = nb(sz);
    off = int'(a[7:0]);
    if (!is_hit(a)) return 1'b0;
    for (int i = 0; i < n; i++) begin
      if (off + i > 255) break;
      m  = spec_mask(off+i);
      nv = (mem[off+i] & ~m) | (d[8*i +: 8] & m);
      if (off+i >= 8'h10 && off+i <= 8'h27 && nv != mem[off+i]) flag = 1'b1;
      if (off+i == 4 && ((nv ^ mem[off+i]) & 8'h03) != 8'h00) flag = 1'b1;
      mem[off+i] = nv;
    end
    return flag;
  endfunction

  task automatic op(input bit w, input bit r, input logic [31:0] a,
                    input logic [1:0] sz, input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; cfg_addr = a; acc_size = sz; wr_data = d;
    if (w) exp_r[(cyc+1)%4] = model_write(a, sz, d);
    else if (r) begin
      exp_v[(cyc+2)%4] = 1'b1;
      exp_d[(cyc+2)%4] = model_read(a, sz);
      exp_t[(cyc+2)%4] = tag;
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    op(1'b1, 1'b0, a, sz, d, "");
  endtask
  task automatic rd(input logic [31:0] a, input logic [1:0] sz, input string tag);
    op(1'b0, 1'b1, a, sz, 32'h0, tag);
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
    end
  endtask

  // per-cycle comparison against the reference ring
  always @(negedge clk) begin
    int s;
    if (cmp_on) begin
      s = cyc % 4;
      checks++;
      if (rd_valid !== exp_v[s] || (exp_v[s] && rd_data !== exp_d[s])) begin
        fails++;
        $display("FAIL %s cyc=%0d actual valid=%0b data=%h expected valid=%0b data=%h",
                 exp_v[s] ? exp_t[s] : "R7/R11", cyc, rd_valid, rd_data, exp_v[s], exp_d[s]);
      end
      checks++;
      if (remap_req !== exp_r[s]) begin
        fails++;
        $display("FAIL R10 cyc=%0d actual remap=%0b expected=%0b", cyc, remap_req, exp_r[s]);
      end
      exp_v[s] = 1'b0;
      exp_r[s] = 1'b0;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 4; i++) begin exp_v[i] = 0; exp_r[i] = 0; exp_d[i] = 0; exp_t[i] = ""; end
    // R6 reset image from the requirement
    {mem[1], mem[0]} = VEN;  {mem[3], mem[2]} = DEV;  mem[8] = REV;
    {mem[11], mem[10], mem[9]} = CLS;
    {mem[8'h2D], mem[8'h2C]} = SVEN; {mem[8'h2F], mem[8'h2E]} = SSYS;
    mem[8'h14] = 8'h01;

    repeat (3) @(negedge clk);
    // R6 outputs in reset
    checks++;
    if (rd_valid !== 1'b0 || remap_req !== 1'b0 || rd_data !== 32'h0) begin
      fails++;
      $display("FAIL R6 reset outputs actual=%0b/%0b/%h expected=0/0/00000000",
               rd_valid, remap_req, rd_data);
    end
    rst = 1'b0;
    cmp_on = 1'b1;

    // R6 identity bytes and BAR presets, R1 decode of own address
    rd(A(8'h00), 2'b10, "R6 ids");
    rd(A(8'h08), 2'b10, "R6 class");
    rd(A(8'h2C), 2'b10, "R6 subsystem");
    rd(A(8'h10), 2'b10, "R6 bar0");
    rd(A(8'h14), 2'b10, "R6 bar1");
    // R4 R5 read-only identity
    wr(A(8'h00), 2'b10, 32'hFFFF_FFFF);
    rd(A(8'h00), 2'b10, "R5 ro ids");
    // R10 command decode bits
    wr(A(8'h04), 2'b01, 32'h0000_FFFF);
    rd(A(8'h04), 2'b01, "R5 cmd mask");
    wr(A(8'h04), 2'b00, 32'h0000_0007);
    wr(A(8'h04), 2'b00, 32'h0000_0004);
    wr(A(8'h04), 2'b00, 32'h0000_0000);
    wr(A(8'h04), 2'b00, 32'h0000_0002);
    // R5 cache line and interrupt line
    wr(A(8'h0C), 2'b00, 32'h0000_00AB);
    wr(A(8'h3C), 2'b10, 32'h1122_3344);
    rd(A(8'h3C), 2'b10, "R5 irq line");
    rd(A(8'h0C), 2'b00, "R5 cache line");
    // R4 R10 base address window
    wr(A(8'h10), 2'b10, 32'hFFFF_FFFF);
    rd(A(8'h10), 2'b10, "R4 bar0 merge");
    wr(A(8'h10), 2'b10, 32'hFFFF_FFFF);
    wr(A(8'h14), 2'b10, 32'h0000_1234);
    rd(A(8'h14), 2'b10, "R4 bar1 merge");
    wr(A(8'h18), 2'b10, 32'hFFFF_FFFF);
    rd(A(8'h18), 2'b10, "R5 bar2 ro");
    // R3 R7 device-specific region, unaligned
    wr(A(8'h40), 2'b10, 32'h0302_0100);
    wr(A(8'h44), 2'b10, 32'h0706_0504);
    rd(A(8'h41), 2'b10, "R7 unaligned word");
    rd(A(8'h43), 2'b01, "R7 unaligned half");
    rd(A(8'h42), 2'b00, "R7 byte upper zero");
    wr(A(8'h7E), 2'b10, 32'hDDCC_BBAA);
    rd(A(8'h7E), 2'b10, "R3 row crossing");
    rd(A(8'h80), 2'b01, "R3 row crossing half");
    wr(A(8'h3E), 2'b10, 32'h4433_2211);
    rd(A(8'h40), 2'b10, "R3 header straddle");
    rd(A(8'h3C), 2'b10, "R5 straddle ro");
    // R3 drop past the end, R8 range faults
    wr(A(8'hFC), 2'b00, 32'h0000_0011);
    wr(A(8'hFD), 2'b00, 32'h0000_0022);
    wr(A(8'hFE), 2'b10, 32'h5566_7788);
    rd(A(8'hFE), 2'b01, "R3 tail bytes");
    rd(A(8'h00), 2'b10, "R3 no wrap");
    rd(A(8'hFC), 2'b10, "R8 last word");
    rd(A(8'hFD), 2'b10, "R8 word overrun");
    rd(A(8'hFF), 2'b01, "R8 half overrun");
    rd(A(8'hFF), 2'b00, "R8 last byte");
    // R9 foreign bus or device/function, R1 field positions
    wr(mk(8'h04, MY_DEVFN, 8'h40), 2'b10, 32'hEEEE_EEEE);
    wr(mk(MY_BUS, 8'h29, 8'h0C), 2'b00, 32'h0000_0055);
    wr(mk(MY_BUS, 8'h08, 8'h10), 2'b10, 32'h1234_5000);
    rd(A(8'h40), 2'b10, "R9 write ignored");
    rd(A(8'h0C), 2'b00, "R9 devfn write ignored");
    rd(A(8'h10), 2'b10, "R1 device field");
    rd(mk(8'h04, MY_DEVFN, 8'h00), 2'b10, "R9 bus miss read");
    rd(mk(MY_BUS, 8'h30, 8'h00), 2'b10, "R1 device miss read");
    // R2 reserved size
    rd(A(8'h00), 2'b11, "R2 reserved read");
    wr(A(8'h0C), 2'b11, 32'h0000_0044);
    rd(A(8'h0C), 2'b00, "R2 reserved write");
    // R11 simultaneous write and read
    op(1'b1, 1'b1, A(8'h50), 2'b10, 32'hCAFE_F00D, "R11");
    rd(A(8'h50), 2'b10, "R11 write kept");
    idle(6);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule